// File: doc/BRIEF.md
# Thermometer-Coded Pixel Column Sparse Readout

This block holds the digital back-end of a column of pixels. Each pixel's small flash converter produces a thermometer vector of comparator bits. On every edge of the bunch-crossing clock, the block turns that vector into a binary amplitude and latches it, together with a hit flag. It does this only for pixels whose hit flag is clear.

Once a pixel holds a hit, it places a request with a priority encoder shared by the column. When readout is enabled, the encoder chooses the pending pixel with the lowest index. It presents that pixel's address and amplitude for one cycle with a valid strobe and clears the pixel's flag. It then goes on to the next pending pixel, one per clock. Empty pixels cost no readout cycles.

A two-bit setting per pixel controls its behaviour. Bit 0 masks the pixel. Bit 1 makes the pixel report a hit at full scale whatever its comparators show. Mask wins when both bits are set.

Top module: `pix_col_readout`

## Requirements
- R1: A captured pixel's amplitude equals the number of ones in its 7-bit thermometer vector (0000111 gives 3). An all-zero vector is not a hit.
- R2: A non-monotonic thermometer vector is still encoded by counting its ones (1010001 gives 3).
- R3: Among the pending pixels, the one with the lowest index is read first. Its index appears on `addr_out`.
- R4: A read is presented with `valid_out` high for one cycle, one clock after the edge that sampled `rd_en` high with a request pending. That pixel's flag is cleared at the same edge, so the next read names a different pixel.
- R5: A pixel with cfg bit 0 set (cfg 01 or 11) never raises a request. A hit it already holds is discarded.
- R6: A pixel with cfg 10 raises a request with amplitude 7, even when all its comparator bits are zero.
- R7: `busy_out` is high exactly while at least one unmasked pixel holds a hit.
- R8: While a pixel's flag is set, new comparator data are ignored. The amplitude later read out is the first one captured.
- R9: With `rd_en` low, `valid_out` stays low and pending hits are kept.
- R10: After reset, `valid_out`, `busy_out`, `addr_out` and `amp_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| thermo_in | input | NPIX*7 | Comparator thermometer vectors, pixel p in bits [7p+6:7p] |
| cfg_in | input | NPIX*2 | Per-pixel setting, pixel p in bits [2p+1:2p]; bit 0 mask, bit 1 force |
| rd_en | input | 1 | Readout enable |
| addr_out | output | $clog2(NPIX) | Index of the pixel being read |
| amp_out | output | 3 | Amplitude of the pixel being read |
| valid_out | output | 1 | Read strobe, one cycle per hit |
| busy_out | output | 1 | At least one request pending |

## Verification
The assertions take for granted that `thermo_in`, `cfg_in` and `rd_en` are synchronous to the bunch-crossing clock and settle between edges. They also assume a pixel's setting changes only between edges, since both mask and busy react to it combinationally.

The stimulus drives every input on the falling edge, so each rising edge sees stable values. Random comparator vectors are sparse and may be non-monotonic, so the bubble-tolerant encoding is exercised. Settings change only now and then, so forced and masked pixels persist across many cycles.

// File: rtl/pix_col_readout.sv
module pix_col_readout #(
  parameter int NPIX = 192,
  parameter int THW  = 7,
  localparam int AW   = $clog2(NPIX),
  localparam int AMPW = $clog2(THW + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPIX*THW-1:0] thermo_in,
  input  logic [NPIX*2-1:0]   cfg_in,
  input  logic                rd_en,
  output logic [AW-1:0]       addr_out,
  output logic [AMPW-1:0]     amp_out,
  output logic                valid_out,
  output logic                busy_out
);

  function automatic logic [AMPW-1:0] ones(input logic [THW-1:0] v);
    logic [AMPW-1:0] n;
    n = '0;
    for (int b = 0; b < THW; b++) n = n + AMPW'(v[b]);
    return n;
  endfunction

  logic [NPIX-1:0] hit_q, req, mask, force_rpt;
  logic [AMPW-1:0] amp_q [NPIX];
  logic [AW-1:0]   sel;
  logic            any_req, take;

  for (genvar p = 0; p < NPIX; p++) begin : g_pix
    assign mask[p]      = cfg_in[2*p];
    assign force_rpt[p] = cfg_in[2*p+1];
    assign req[p]       = hit_q[p] & ~mask[p];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hit_q[p] <= 1'b0;
        amp_q[p] <= '0;
      end else if (mask[p]) begin
        hit_q[p] <= 1'b0;
      end else if (take && sel == AW'(p)) begin
        hit_q[p] <= 1'b0;
      end else if (!hit_q[p]) begin
        if (force_rpt[p]) begin
          hit_q[p] <= 1'b1;
          amp_q[p] <= AMPW'(THW);
        end else if (|thermo_in[p*THW +: THW]) begin
          hit_q[p] <= 1'b1;
          amp_q[p] <= ones(thermo_in[p*THW +: THW]);
        end
      end
    end

    AST_MASK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      mask[p] |=> !hit_q[p]);  // R5
    AST_HELD_AMP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(hit_q[p]) && hit_q[p]) |-> $stable(amp_q[p]));  // R8
  end

  always_comb begin
    sel = '0;
    for (int i = NPIX - 1; i >= 0; i--)
      if (req[i]) sel = AW'(i);
  end

  assign any_req  = |req;
  assign take     = rd_en & any_req;
  assign busy_out = any_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_out <= 1'b0;
      addr_out  <= '0;
      amp_out   <= '0;
    end else begin
      valid_out <= take;
      if (take) begin
        addr_out <= sel;
        amp_out  <= amp_q[sel];
      end
    end
  end

  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !valid_out);  // R9
  AST_READ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out |-> $past(busy_out));  // R7
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out |-> !hit_q[addr_out]);  // R4
  AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_out && $past(valid_out)) |-> (addr_out != $past(addr_out)));  // R4

endmodule

// File: tb/test_pix_col_readout.sv
module test_pix_col_readout;
  localparam int NPIX = 192;
  localparam int THW  = 7;
  localparam int AW   = $clog2(NPIX);
  localparam int CLK_PERIOD = 25;

  logic clk = 0, rst_n = 0, rd_en = 0;
  logic [NPIX*THW-1:0] th = '0;
  logic [NPIX*2-1:0]   cfg = '0;
  logic [AW-1:0] addr_out;
  logic [2:0]    amp_out;
  logic          valid_out, busy_out;

  int n_cmp = 0, n_bad = 0;
  bit m_hit [NPIX];
  int m_amp [NPIX];
  int e_valid = 0, e_addr = 0, e_amp = 0, e_busy = 0;

  pix_col_readout #(.NPIX(NPIX), .THW(THW)) i_pix_col_readout (
    .clk(clk), .rst_n(rst_n), .thermo_in(th), .cfg_in(cfg), .rd_en(rd_en),
    .addr_out(addr_out), .amp_out(amp_out), .valid_out(valid_out), .busy_out(busy_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: act=hung exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  function automatic int popc(input logic [6:0] v);
    int n = 0;
    for (int b = 0; b < 7; b++) n += int'(v[b]);
    return n;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    int s = -1;
    for (int p = NPIX - 1; p >= 0; p--)
      if (m_hit[p] && !cfg[2*p]) s = p;
    e_valid = (rd_en && s >= 0) ? 1 : 0;
    if (e_valid == 1) begin e_addr = s; e_amp = m_amp[s]; end
    for (int p = 0; p < NPIX; p++) begin
      if (cfg[2*p]) m_hit[p] = 0;
      else if (e_valid == 1 && p == s) m_hit[p] = 0;
      else if (!m_hit[p]) begin
        if (cfg[2*p+1]) begin m_hit[p] = 1; m_amp[p] = 7; end
        else if (th[p*7 +: 7] != 0) begin m_hit[p] = 1; m_amp[p] = popc(th[p*7 +: 7]); end
      end
    end
    e_busy = 0;
    for (int p = 0; p < NPIX; p++) if (m_hit[p] && !cfg[2*p]) e_busy = 1;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R4 valid", int'(valid_out), e_valid);
    chk("R3 addr", int'(addr_out), e_addr);
    chk("R1 amp", int'(amp_out), e_amp);
    chk("R7 busy", int'(busy_out), e_busy);
  endtask

  task automatic drain();
    th = '0; rd_en = 1;
    for (int k = 0; k < 12; k++) step();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int p = 0; p < NPIX; p++) begin m_hit[p] = 0; m_amp[p] = 0; end
    @(negedge clk); @(negedge clk);
    chk("R10 valid", int'(valid_out), 0);
    chk("R10 busy", int'(busy_out), 0);
    chk("R10 addr", int'(addr_out), 0);
    chk("R10 amp", int'(amp_out), 0);
    rst_n = 1;
    @(negedge clk);

    th[5*7 +: 7] = 7'b1010001; step(); th = '0; rd_en = 1; step();
    chk("R2 bubble amp", int'(amp_out), 3);
    chk("R2 addr", int'(addr_out), 5);
    drain();

    cfg[2*2 +: 2] = 2'b01; th[2*7 +: 7] = 7'h7f; th[9*7 +: 7] = 7'b0000111;
    rd_en = 0; step(); th = '0; rd_en = 1; step();
    chk("R5 masked skipped", int'(addr_out), 9);
    chk("R1 amp 3", int'(amp_out), 3);
    step();
    chk("R5 no read of masked", int'(valid_out), 0);
    cfg = '0; drain();

    cfg[0 +: 2] = 2'b10; rd_en = 0; step(); cfg = '0; rd_en = 1; step();
    chk("R6 forced addr", int'(addr_out), 0);
    chk("R6 forced amp", int'(amp_out), 7);
    drain();

    rd_en = 0; th[3*7 +: 7] = 7'b0000001; step();
    th[3*7 +: 7] = 7'h7f; step(); step();
    chk("R9 no valid", int'(valid_out), 0);
    chk("R9 kept", int'(busy_out), 1);
    th = '0; rd_en = 1; step();
    chk("R8 first amp kept", int'(amp_out), 1);
    drain();

    th[40*7 +: 7] = 7'b0001111; th[7*7 +: 7] = 7'b0000011; rd_en = 0; step();
    th = '0; rd_en = 1; step();
    chk("R3 lowest first", int'(addr_out), 7);
    step();
    chk("R4 next pixel", int'(addr_out), 40);
    chk("R4 next amp", int'(amp_out), 4);
    drain();

    for (int c = 0; c < 2000; c++) begin
      for (int p = 0; p < NPIX; p++) begin
        th[p*7 +: 7] = ($urandom_range(0, 39) == 0) ? 7'($urandom) : 7'h0;
        if ($urandom_range(0, 299) == 0) cfg[2*p +: 2] = 2'($urandom);
      end
      rd_en = ($urandom_range(0, 3) != 0);
      step();
    end
    cfg = '0;
    th = '0; rd_en = 1;
    for (int k = 0; k < NPIX + 4; k++) step();
    chk("R7 idle after drain", int'(busy_out), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule